// File: doc/BRIEF.md
# Bus-Mapped Accelerator Shell

This block connects a small compute engine to a host over a Wishbone B4 classic slave port. The host writes the engine's operand buffers through an input window, writes a control word to start a run, polls a status word until the run is complete, and then reads the results back through an output window. A cycle counter records how many clocks the engine spent busy on the most recent run.

The engine behind the shell is a stub. It takes `NUM_IN` operand buffers of `DEPTH` words each. It walks the entries in index order, one per clock, and stores the word sum of all buffers at each index into the result memory. All buffers, the result memory and the bus data are `DATA_W` bits wide. Every access is a single two-cycle handshake: the master raises strobe, and the slave answers with acknowledge in the following cycle.

Top module: `wbacc_shell`

## Requirements
- R1: After reset, acknowledge is low, read data is zero, the status word reads 0 and the cycle-count word reads 0.
- R2: Acknowledge rises in the clock after a cycle in which cyc and stb are both high. It lasts one clock and appears only while cyc and stb are high. While strobe is held high, acknowledge alternates high and low, so each access takes two cycles.
- R3: A write to byte address 0x0000 with bit 0 set starts the engine once. A write there with bit 0 clear starts nothing. Reads of 0x0000 return 0.
- R4: The status word at byte address 0x0004 has busy in bit 0 and done in bit 1. Done becomes 1 when a run finishes and returns to 0 at the next start.
- R5: The word at byte address 0x0008 is cleared by a start and counts every clock in which the engine is busy. A run takes `DEPTH` clocks, so the word reads `DEPTH` afterwards, and it keeps that value once the run has finished.
- R6: Input buffer b, entry i, is written at byte address 0x1000 + 4*(b*DEPTH + i), so each buffer follows directly after the one before it.
- R7: Byte address 0x8000 + 4*i returns result entry i. After a run, that entry equals the sum modulo 2^DATA_W of entry i across all input buffers. Data comes from a synchronous read, with the address taken in the strobe cycle.
- R8: Writes to the status word, the cycle-count word or the output window are acknowledged but change nothing.
- R9: Reads from any address outside the control, status, count and output locations return 0. This includes the input window, which cannot be read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Strobe for this slave |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_adr_i | input | ADDR_W | Byte address |
| wb_dat_i | input | DATA_W | Write data |
| wb_dat_o | output | DATA_W | Read data, valid with acknowledge, zero otherwise |
| wb_ack_o | output | 1 | Acknowledge |

## Verification
The bench builds the shell with three input buffers of four words each. This places buffer boundaries at word offsets 4 and 8, inside the input window, so a wrong buffer-to-address mapping would corrupt the sums. With buffers that short, the bench can write every input word, read every result entry, and sweep every word address of the low register page. It also probes the gaps after both windows. Three operand patterns are used, one of which wraps the adder, and each run confirms a cycle count of exactly four.

// File: rtl/wbacc_pkg.sv
package wbacc_pkg;

   // word-aligned byte offsets of the fixed locations
   localparam int unsigned CTRL_OFS = 32'h0000;
   localparam int unsigned STAT_OFS = 32'h0004;
   localparam int unsigned CNT_OFS  = 32'h0008;
   localparam int unsigned IN_BASE  = 32'h1000;
   localparam int unsigned OUT_BASE = 32'h8000;

   // bit positions in control and status words
   localparam int unsigned GO_BIT   = 0;
   localparam int unsigned BUSY_BIT = 0;
   localparam int unsigned DONE_BIT = 1;

   typedef enum logic [2:0] {
      RGN_NONE,
      RGN_CTRL,
      RGN_STAT,
      RGN_CNT,
      RGN_IN,
      RGN_OUT
   } wbacc_rgn_e;

endpackage

// File: rtl/wbacc_decode.sv
module wbacc_decode
   import wbacc_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int NUM_IN = 2,
   parameter int DEPTH  = 8,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int BUF_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
   input  logic [ADDR_W-1:0] adr_i,
   output wbacc_rgn_e        rgn_o,
   output logic [BUF_W-1:0]  in_buf_o,
   output logic [IDX_W-1:0]  in_idx_o,
   output logic [IDX_W-1:0]  out_idx_o
);

   localparam int WA_W     = ADDR_W - 2;
   localparam int IN_WORDS = NUM_IN * DEPTH;

   if (ADDR_W < 16) begin : g_bad_addr
      $error("ADDR_W must cover the output window");
   end
   if ((DEPTH < 2) || ((1 << IDX_W) != DEPTH)) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end
   if ((IN_BASE / 4) + IN_WORDS > (OUT_BASE / 4)) begin : g_bad_overlap
      $error("input window runs into the output window");
   end
   if (IDX_W + BUF_W > WA_W) begin : g_bad_fields
      $error("buffer fields exceed the word address");
   end

   logic [WA_W-1:0] wadr;
   logic [WA_W-1:0] in_word;
   logic [WA_W-1:0] out_word;
   logic [1:0]      unused_lane;

   assign wadr        = adr_i[ADDR_W-1:2];
   assign unused_lane = adr_i[1:0];
   assign in_word     = wadr - WA_W'(IN_BASE / 4);
   assign out_word    = wadr - WA_W'(OUT_BASE / 4);

   always_comb begin
      rgn_o = RGN_NONE;
      if (wadr == WA_W'(CTRL_OFS / 4))      rgn_o = RGN_CTRL;
      else if (wadr == WA_W'(STAT_OFS / 4)) rgn_o = RGN_STAT;
      else if (wadr == WA_W'(CNT_OFS / 4))  rgn_o = RGN_CNT;
      else if (wadr >= WA_W'(IN_BASE / 4) && in_word < WA_W'(IN_WORDS))
         rgn_o = RGN_IN;
      else if (wadr >= WA_W'(OUT_BASE / 4) && out_word < WA_W'(DEPTH))
         rgn_o = RGN_OUT;
   end

   assign in_idx_o  = in_word[IDX_W-1:0];
   assign in_buf_o  = (NUM_IN > 1) ? in_word[IDX_W +: BUF_W] : '0;
   assign out_idx_o = out_word[IDX_W-1:0];

endmodule

// File: rtl/wbacc_ctrl.sv
module wbacc_ctrl #(
   parameter int CNT_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             go_i,
   input  logic             core_busy_i,
   input  logic             core_done_i,
   output logic             start_o,
   output logic             done_flag_o,
   output logic [CNT_W-1:0] cnt_o
);

   if (CNT_W < 4) begin : g_bad_cnt
      $error("CNT_W too small");
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         start_o     <= 1'b0;
         done_flag_o <= 1'b0;
         cnt_o       <= '0;
      end else begin
         start_o <= go_i;
         if (start_o)          done_flag_o <= 1'b0;
         else if (core_done_i) done_flag_o <= 1'b1;
         if (start_o)          cnt_o <= '0;
         else if (core_busy_i) cnt_o <= cnt_o + 1'b1;
      end
   end

   AST_START_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_o |=> !start_o); // R3
   AST_DONE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_o |=> !done_flag_o); // R4
   AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_o |=> (cnt_o == '0)); // R5
   AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!core_busy_i && !start_o) |=> $stable(cnt_o)); // R5

endmodule

// File: rtl/wbacc_stub_core.sv
module wbacc_stub_core #(
   parameter int DATA_W = 32,
   parameter int NUM_IN = 2,
   parameter int DEPTH  = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     start_i,
   input  logic [NUM_IN*DATA_W-1:0] in_rdata_i,
   output logic [IDX_W-1:0]         rd_idx_o,
   output logic                     out_we_o,
   output logic [IDX_W-1:0]         out_idx_o,
   output logic [DATA_W-1:0]        out_wdata_o,
   output logic                     busy_o,
   output logic                     done_o
);

   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] sum;

   if (NUM_IN == 1) begin : g_pass
      assign sum = in_rdata_i;
   end else begin : g_add
      always_comb begin
         sum = '0;
         for (int b = 0; b < NUM_IN; b++) begin
            sum = sum + in_rdata_i[b*DATA_W +: DATA_W];
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         idx_q  <= '0;
         busy_o <= 1'b0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (start_i) begin
            idx_q  <= '0;
            busy_o <= 1'b1;
         end else if (busy_o) begin
            idx_q <= idx_q + 1'b1;
            if (idx_q == IDX_W'(DEPTH - 1)) begin
               busy_o <= 1'b0;
               done_o <= 1'b1;
            end
         end
      end
   end

   assign rd_idx_o    = idx_q;
   assign out_idx_o   = idx_q;
   assign out_we_o    = busy_o;
   assign out_wdata_o = sum;

   AST_BUSY_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> busy_o); // R3
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> ($past(busy_o) && !busy_o)); // R5

endmodule

// File: rtl/wbacc_shell.sv
module wbacc_shell
   import wbacc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 16,
   parameter int NUM_IN = 2,
   parameter int DEPTH  = 8,
   parameter int CNT_W  = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wb_cyc_i,
   input  logic              wb_stb_i,
   input  logic              wb_we_i,
   input  logic [ADDR_W-1:0] wb_adr_i,
   input  logic [DATA_W-1:0] wb_dat_i,
   output logic [DATA_W-1:0] wb_dat_o,
   output logic              wb_ack_o
);

   localparam int IDX_W = $clog2(DEPTH);
   localparam int BUF_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

   if (CNT_W > DATA_W || DATA_W < 2) begin : g_bad_width
      $error("DATA_W must hold the counter and two status bits");
   end

   wbacc_rgn_e              rgn;
   logic [BUF_W-1:0]        in_buf;
   logic [IDX_W-1:0]        in_idx;
   logic [IDX_W-1:0]        out_idx;
   logic                    ack_q;
   logic                    acc_req;
   logic                    wr_req;
   logic                    sel_out_q;
   logic [DATA_W-1:0]       rdat_q;
   logic [DATA_W-1:0]       omem_q;
   logic [DATA_W-1:0]       reg_val;
   logic                    start;
   logic                    done_flag;
   logic [CNT_W-1:0]        cnt;
   logic                    core_busy;
   logic                    core_done;
   logic [IDX_W-1:0]        core_rd_idx;
   logic                    core_we;
   logic [IDX_W-1:0]        core_widx;
   logic [DATA_W-1:0]       core_wdata;
   logic [NUM_IN*DATA_W-1:0] in_rdata;
   logic [DATA_W-1:0]       omem [DEPTH];

   wbacc_decode #(.ADDR_W(ADDR_W), .NUM_IN(NUM_IN), .DEPTH(DEPTH)) u_dec (
      .adr_i     (wb_adr_i),
      .rgn_o     (rgn),
      .in_buf_o  (in_buf),
      .in_idx_o  (in_idx),
      .out_idx_o (out_idx)
   );

   // bus handshake: request in strobe cycle, acknowledge one clock later
   assign acc_req  = wb_cyc_i && wb_stb_i && !ack_q;
   assign wr_req   = acc_req && wb_we_i;
   assign wb_ack_o = ack_q && wb_cyc_i && wb_stb_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) ack_q <= 1'b0;
      else         ack_q <= acc_req;
   end

   wbacc_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .go_i        (wr_req && (rgn == RGN_CTRL) && wb_dat_i[GO_BIT]),
      .core_busy_i (core_busy),
      .core_done_i (core_done),
      .start_o     (start),
      .done_flag_o (done_flag),
      .cnt_o       (cnt)
   );

   // input buffers, one memory per buffer
   for (genvar b = 0; b < NUM_IN; b++) begin : g_inbuf
      logic [DATA_W-1:0] imem [DEPTH];
      always_ff @(posedge clk_i) begin
         if (wr_req && (rgn == RGN_IN) && (in_buf == BUF_W'(b)))
            imem[in_idx] <= wb_dat_i;
      end
      assign in_rdata[b*DATA_W +: DATA_W] = imem[core_rd_idx];
   end

   wbacc_stub_core #(.DATA_W(DATA_W), .NUM_IN(NUM_IN), .DEPTH(DEPTH)) u_core (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_i     (start),
      .in_rdata_i  (in_rdata),
      .rd_idx_o    (core_rd_idx),
      .out_we_o    (core_we),
      .out_idx_o   (core_widx),
      .out_wdata_o (core_wdata),
      .busy_o      (core_busy),
      .done_o      (core_done)
   );

   // result memory: engine writes, bus reads synchronously
   always_ff @(posedge clk_i) begin
      if (core_we) omem[core_widx] <= core_wdata;
      if (acc_req) omem_q <= omem[out_idx];
   end

   always_comb begin
      reg_val = '0;
      case (rgn)
         RGN_STAT: begin
            reg_val[BUSY_BIT] = core_busy;
            reg_val[DONE_BIT] = done_flag;
         end
         RGN_CNT: reg_val = DATA_W'(cnt);
         default: reg_val = '0;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         rdat_q    <= '0;
         sel_out_q <= 1'b0;
      end else if (acc_req) begin
         rdat_q    <= wb_we_i ? '0 : reg_val;
         sel_out_q <= !wb_we_i && (rgn == RGN_OUT);
      end
   end

   assign wb_dat_o = !wb_ack_o ? '0 : (sel_out_q ? omem_q : rdat_q);

   AST_ACK_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wb_ack_o |-> $past(wb_cyc_i && wb_stb_i)); // R2
   AST_ACK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wb_ack_o |=> !wb_ack_o); // R2
   AST_NO_START_WITHOUT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start |-> $past(wb_cyc_i && wb_stb_i && wb_we_i)); // R3

endmodule

// File: tb/wbacc_shell_tb_top.sv
`timescale 1ns/1ps
module wbacc_shell_tb_top;

   localparam int DW = 32;
   localparam int AW = 16;
   localparam int NI = 3;
   localparam int DP = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cyc = 1'b0, stb = 1'b0, we = 1'b0;
   logic [AW-1:0] adr = '0;
   logic [DW-1:0] dat_w = '0;
   logic [DW-1:0] dat_r;
   logic          ack;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [DW-1:0] inv [NI][DP];

   always #10 clk = ~clk;

   wbacc_shell #(.DATA_W(DW), .ADDR_W(AW), .NUM_IN(NI), .DEPTH(DP), .CNT_W(32)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
      .wb_adr_i(adr), .wb_dat_i(dat_w), .wb_dat_o(dat_r), .wb_ack_o(ack)
   );

   task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wb_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      cyc = 1; stb = 1; we = 1; adr = a; dat_w = d;
      @(negedge clk);
      chk(ack === 1'b1, "R2 write ack", DW'(ack), 1);
      cyc = 0; stb = 0; we = 0;
      @(negedge clk);
   endtask

   task automatic wb_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      cyc = 1; stb = 1; we = 0; adr = a;
      @(negedge clk);
      chk(ack === 1'b1, "R2 read ack", DW'(ack), 1);
      d = dat_r;
      cyc = 0; stb = 0;
      @(negedge clk);
   endtask

   function automatic logic [DW-1:0] pat(input int k, input int b, input int i);
      case (k)
         0: return DW'(b * 16 + i + 1);
         1: return 32'h0101_0101 * DW'(k + b) + DW'(i << 8);
         default: return 32'hFFFF_FFF0 - DW'(b * 3) + DW'(i * 7);
      endcase
   endfunction

   function automatic logic [DW-1:0] exp_out(input int i);
      logic [DW-1:0] s = '0;
      for (int b = 0; b < NI; b++) s = s + inv[b][i];
      return s;
   endfunction

   task automatic wait_done();
      logic [DW-1:0] v;
      bit seen = 0;
      for (int t = 0; t < 64 && !seen; t++) begin
         wb_rd(16'h0004, v);
         if (v[1]) seen = 1;
      end
      chk(seen, "R4 done reached", DW'(seen), 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(ack === 1'b0, "R1 ack idle", DW'(ack), 0);
      chk(dat_r === '0, "R1 data idle", dat_r, 0);
      wb_rd(16'h0004, v); chk(v === 0, "R1 status", v, 0);
      wb_rd(16'h0008, v); chk(v === 0, "R1 count", v, 0);

      // R2: strobe held, ack alternates
      cyc = 1; stb = 1; we = 0; adr = 16'h0004;
      #1 chk(ack === 1'b0, "R2 no ack before edge", DW'(ack), 0);
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         chk(ack === ((c % 2) == 0), "R2 back-to-back", DW'(ack), DW'((c % 2) == 0));
      end
      stb = 0;
      @(negedge clk);
      chk(ack === 1'b0, "R2 no ack without stb", DW'(ack), 0);
      @(negedge clk);
      chk(ack === 1'b0, "R2 no ack without stb", DW'(ack), 0);
      cyc = 0;
      @(negedge clk);

      for (int k = 0; k < 3; k++) begin
         for (int b = 0; b < NI; b++)
            for (int i = 0; i < DP; i++) begin
               inv[b][i] = pat(k, b, i);
               wb_wr(AW'(32'h1000 + 4 * (b * DP + i)), inv[b][i]);  // R6 layout
            end
         wb_wr(16'h0000, 32'h1);
         wb_rd(16'h0004, v); chk(v === 32'h1, "R4 busy during run", v, 1);
         wb_rd(16'h0000, v); chk(v === 0, "R3 control reads zero", v, 0);
         wait_done();
         wb_rd(16'h0004, v); chk(v === 32'h2, "R4 done, not busy", v, 2);
         wb_rd(16'h0008, v); chk(v === DP, "R5 run length", v, DP);
         repeat (5) @(negedge clk);
         wb_rd(16'h0008, v); chk(v === DP, "R5 count holds", v, DP);
         for (int i = 0; i < DP; i++) begin
            wb_rd(AW'(32'h8000 + 4 * i), v);
            chk(v === exp_out(i), "R6 R7 result entry", v, exp_out(i));
         end
      end

      // R3: bit 0 clear starts nothing
      wb_wr(16'h0000, 32'hFFFF_FFFE);
      repeat (3) @(negedge clk);
      wb_rd(16'h0004, v); chk(v === 32'h2, "R3 no start on bit0=0", v, 2);
      // R4: next start clears done
      wb_wr(16'h0000, 32'h1);
      wb_rd(16'h0004, v); chk(v === 32'h1, "R4 done cleared by start", v, 1);
      wait_done();

      // R8: ignored writes
      wb_wr(16'h0004, 32'hFFFF_FFFF);
      wb_rd(16'h0004, v); chk(v === 32'h2, "R8 status unwritable", v, 2);
      wb_wr(16'h0008, 32'h0000_1234);
      wb_rd(16'h0008, v); chk(v === DP, "R8 count unwritable", v, DP);
      for (int i = 0; i < DP; i++) begin
         wb_wr(AW'(32'h8000 + 4 * i), 32'hDEAD_BEEF);
         wb_rd(AW'(32'h8000 + 4 * i), v);
         chk(v === exp_out(i), "R8 output unwritable", v, exp_out(i));
      end

      // R9: sweep of unmapped space and the write-only input window
      for (int a = 16'h000C; a < 16'h1000 + 4 * (NI * DP) + 64; a += 4) begin
         if (a >= 16'h0FC0 || a < 16'h0100) begin
            wb_rd(AW'(a), v); chk(v === 0, "R9 unmapped/input read", v, 0);
         end
      end
      for (int a = 16'h8000 + 4 * DP; a < 16'h8000 + 4 * DP + 64; a += 4) begin
         wb_rd(AW'(a), v); chk(v === 0, "R9 past output window", v, 0);
      end
      wb_rd(16'hFFFC, v); chk(v === 0, "R9 top of space", v, 0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule